// File: doc/BRIEF.md
# PLL Divider Parameter Search Engine

This block chooses the three divider codes of a display PLL: a reference divider, a feedback multiplier and a post divider. The codes are picked so that the synthesized frequency lands as close as possible to a requested pixel rate. Software or a mode-set sequencer supplies the reference frequency and the target frequency, both as unsigned integers in Hz, and pulses `start`. The engine latches both values and walks a fixed candidate space, evaluating one candidate per clock. When the walk ends it pulses `done` and holds the winning codes, the frequency they produce and the absolute error.

The walk is ordered to favour low jitter. The reference divider code is the slowest loop and runs upward from 0. The multiplier code is the middle loop and runs downward from its top. The post divider code is the fastest loop and runs upward. A multiplier/reference pair whose intermediate frequency falls outside the oscillator window is dismissed in a single cycle, together with all of its post divider values. A winner is replaced only by a strictly closer candidate, and an exact hit ends the walk at once.

Top module: `pll_div_search`

## Requirements
- R1: Reset state: `done`=0, `codeM`=0, `codeN`=0, `codeP`=0, `outFreq`=0 and `absErr`=32'hFFFFFFFF.
- R2: For codes m, n, p the intermediate frequency is trunc(fin·(n+1)/(m+1)), computed at 64 bits, and the output frequency is trunc(intermediate/(p+1)). `outFreq` reports that output frequency for the reported codes.
- R3: One candidate is evaluated per cycle. The order is m = 0..3 (outermost), then n = 119 down to 39, then p = 1..31 (innermost). A pair whose intermediate frequency is out of range takes exactly one cycle and skips all of its p values.
- R4: The intermediate frequency is valid only when it lies between 1000 and 2,048,000,000 inclusive.
- R5: A candidate whose output frequency is 400,000,000 or more is never accepted. `outFreq` is always below 400,000,000.
- R6: The held result changes only when a candidate's absolute error is strictly smaller than the held error. Among equal errors the earliest in walk order is kept.
- R7: A candidate with zero error ends the search in the cycle it is evaluated.
- R8: If no candidate is acceptable, the codes and `outFreq` report 0 and `absErr` reports 32'hFFFFFFFF.
- R9: `done` is high for exactly one cycle. It rises k clock edges after the edge that samples `start`, where k is the number of candidates evaluated.
- R10: The result outputs hold their values from `done` until the next `start`. A new `start` discards the previous result before the new walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a search; sampled when idle |
| refFreq | input | 32 | Reference frequency in Hz, latched on start |
| targetFreq | input | 32 | Requested output frequency in Hz, latched on start |
| done | output | 1 | One-cycle pulse when the result is final |
| codeM | output | 2 | Reference divider code (divide by code+1) |
| codeN | output | 7 | Feedback multiplier code (multiply by code+1) |
| codeP | output | 5 | Post divider code (divide by code+1) |
| outFreq | output | 32 | Output frequency produced by the reported codes |
| absErr | output | 32 | Absolute difference between outFreq and target |

## Verification
The result is due exactly k edges after the edge that samples `start`, where k counts every candidate in the walk up to the exact hit or the end. An out-of-range pair counts as one candidate. The reference model in the bench replays the walk and produces both the expected codes and this k. The monitor records the edge count when `done` is seen and compares it with k. It checks on the following cycle that `done` has fallen, and six cycles later the driver checks that every result output is unchanged.

// File: rtl/pll_div_search_pkg.sv
package pll_div_search_pkg;

  // Strobes from the sequencer to the datapath.
  typedef struct packed {
    logic init;   // latch operands, clear result, load first candidate
    logic eval;   // evaluate current candidate and advance
  } srchCtl_t;

  // Flags from the datapath back to the sequencer.
  typedef struct packed {
    logic exact;  // current candidate is acceptable with zero error
    logic last;   // current candidate is the final one of the walk
  } srchStat_t;

endpackage

// File: rtl/pll_div_search_ctl.sv
module pll_div_search_ctl
  import pll_div_search_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  srchStat_t stat,
  output srchCtl_t  ctl,
  output logic      done
);

  typedef enum logic {S_IDLE, S_RUN} state_t;
  state_t state;
  logic   finish;

  always_comb begin
    ctl.init = (state == S_IDLE) && start;
    ctl.eval = (state == S_RUN);
    finish   = ctl.eval && (stat.exact || stat.last);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      done  <= 1'b0;
    end else begin
      done <= finish;
      if (ctl.init)    state <= S_RUN;
      else if (finish) state <= S_IDLE;
    end
  end

  // R9: completion is a single-cycle pulse
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: a sampled start opens a walk and never signals completion on the next edge
  assert_start_runs_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.init |=> (state == S_RUN) && !done);

  // R7: an exact hit closes the walk on the following edge
  assert_exact_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.eval && stat.exact) |=> done && (state == S_IDLE));

endmodule

// File: rtl/pll_div_search_dp.sv
module pll_div_search_dp
  import pll_div_search_pkg::*;
#(
  parameter int unsigned FREQ_W    = 32,
  parameter int unsigned M_LAST    = 3,
  parameter int unsigned N_HIGH    = 119,
  parameter int unsigned N_LOW     = 39,
  parameter int unsigned P_LOW     = 1,
  parameter int unsigned P_HIGH    = 31,
  parameter int unsigned VCO_MIN   = 1000,
  parameter int unsigned VCO_MAX   = 2048000000,
  parameter int unsigned OUT_LIMIT = 400000000,
  localparam int unsigned M_W      = $clog2(M_LAST + 1),
  localparam int unsigned N_W      = $clog2(N_HIGH + 1),
  localparam int unsigned P_W      = $clog2(P_HIGH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  srchCtl_t          ctl,
  input  logic [FREQ_W-1:0] refFreq,
  input  logic [FREQ_W-1:0] targetFreq,
  output srchStat_t         stat,
  output logic [M_W-1:0]    bestM,
  output logic [N_W-1:0]    bestN,
  output logic [P_W-1:0]    bestP,
  output logic [FREQ_W-1:0] bestOut,
  output logic [FREQ_W-1:0] bestErr
);

  logic [FREQ_W-1:0] refReg, tgtReg;
  logic [M_W-1:0]    mCnt;
  logic [N_W-1:0]    nCnt;
  logic [P_W-1:0]    pCnt;

  logic [63:0]       prod, vco, quot;
  logic [FREQ_W-1:0] candOut, diff;
  logic              vcoOk, outOk, better, pairDone;

  // Candidate evaluation: one full candidate per cycle.
  always_comb begin
    prod     = 64'(refReg) * (64'(nCnt) + 64'd1);
    vco      = prod / (64'(mCnt) + 64'd1);
    vcoOk    = (vco >= 64'(VCO_MIN)) && (vco <= 64'(VCO_MAX));
    quot     = vco / (64'(pCnt) + 64'd1);
    outOk    = vcoOk && (quot < 64'(OUT_LIMIT));
    candOut  = quot[FREQ_W-1:0];
    diff     = (candOut >= tgtReg) ? (candOut - tgtReg) : (tgtReg - candOut);
    better   = outOk && (diff < bestErr);
    pairDone = !vcoOk || (pCnt == P_W'(P_HIGH));
    stat.exact = outOk && (diff == '0);
    stat.last  = (mCnt == M_W'(M_LAST)) && (nCnt == N_W'(N_LOW)) && pairDone;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      refReg  <= '0;
      tgtReg  <= '0;
      mCnt    <= '0;
      nCnt    <= N_W'(N_HIGH);
      pCnt    <= P_W'(P_LOW);
      bestM   <= '0;
      bestN   <= '0;
      bestP   <= '0;
      bestOut <= '0;
      bestErr <= '1;
    end else if (ctl.init) begin
      refReg  <= refFreq;
      tgtReg  <= targetFreq;
      mCnt    <= '0;
      nCnt    <= N_W'(N_HIGH);
      pCnt    <= P_W'(P_LOW);
      bestM   <= '0;
      bestN   <= '0;
      bestP   <= '0;
      bestOut <= '0;
      bestErr <= '1;
    end else if (ctl.eval) begin
      if (better) begin
        bestM   <= mCnt;
        bestN   <= nCnt;
        bestP   <= pCnt;
        bestOut <= candOut;
        bestErr <= diff;
      end
      if (pairDone) begin
        pCnt <= P_W'(P_LOW);
        if (nCnt == N_W'(N_LOW)) begin
          nCnt <= N_W'(N_HIGH);
          mCnt <= mCnt + M_W'(1);
        end else begin
          nCnt <= nCnt - N_W'(1);
        end
      end else begin
        pCnt <= pCnt + P_W'(1);
      end
    end
  end

  // R6: the held error can only shrink while walking
  assert_err_nonincrease_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.eval |=> (bestErr <= $past(bestErr)));

  // R5: the reported output frequency never reaches the output ceiling
  assert_out_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bestOut < FREQ_W'(OUT_LIMIT));

  // R3: multiplier counter stays inside its sweep window
  assert_n_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (nCnt >= N_W'(N_LOW)) && (nCnt <= N_W'(N_HIGH)));

  // R3: post divider counter stays inside its sweep window
  assert_p_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pCnt >= P_W'(P_LOW)) && (pCnt <= P_W'(P_HIGH)));

  // R10: with no strobe the result registers hold
  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.init && !ctl.eval) |=> $stable(bestErr) && $stable(bestOut)
      && $stable(bestM) && $stable(bestN) && $stable(bestP));

endmodule

// File: rtl/pll_div_search.sv
module pll_div_search
  import pll_div_search_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] refFreq,
  input  logic [31:0] targetFreq,
  output logic        done,
  output logic [1:0]  codeM,
  output logic [6:0]  codeN,
  output logic [4:0]  codeP,
  output logic [31:0] outFreq,
  output logic [31:0] absErr
);

  srchCtl_t  ctl;
  srchStat_t stat;

  pll_div_search_ctl u_ctl (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .stat  (stat),
    .ctl   (ctl),
    .done  (done)
  );

  pll_div_search_dp #(
    .FREQ_W    (32),
    .M_LAST    (3),
    .N_HIGH    (119),
    .N_LOW     (39),
    .P_LOW     (1),
    .P_HIGH    (31),
    .VCO_MIN   (1000),
    .VCO_MAX   (2048000000),
    .OUT_LIMIT (400000000)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl        (ctl),
    .refFreq    (refFreq),
    .targetFreq (targetFreq),
    .stat       (stat),
    .bestM      (codeM),
    .bestN      (codeN),
    .bestP      (codeP),
    .bestOut    (outFreq),
    .bestErr    (absErr)
  );

endmodule

// File: tb/pll_div_search_tb.sv
module pll_div_search_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] refFreq = '0;
  logic [31:0] targetFreq = '0;
  logic        done;
  logic [1:0]  codeM;
  logic [6:0]  codeN;
  logic [4:0]  codeP;
  logic [31:0] outFreq;
  logic [31:0] absErr;

  always #10 clk = ~clk;  // 50 MHz

  pll_div_search u_dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .refFreq(refFreq), .targetFreq(targetFreq),
    .done(done), .codeM(codeM), .codeN(codeN), .codeP(codeP),
    .outFreq(outFreq), .absErr(absErr)
  );

  typedef struct {
    longint unsigned m, n, p, outF, err, cyc;
  } exp_t;

  exp_t            sbQ[$];
  int              vecCnt = 0;
  int              errCnt = 0;
  longint unsigned cycCnt = 0;
  longint unsigned startAt = 0;
  bit              finished = 0;

  always_ff @(posedge clk) cycCnt <= cycCnt + 64'd1;

  task automatic chk(input string req, input longint unsigned act, input longint unsigned expv);
    vecCnt++;
    if (act !== expv) begin
      errCnt++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Reference walk built from R2..R8: codes, output, error and candidate count.
  function automatic exp_t model(input longint unsigned fin, input longint unsigned tgt);
    exp_t r;
    r.m = 0; r.n = 0; r.p = 0; r.outF = 0; r.err = 64'hFFFFFFFF; r.cyc = 0;
    for (int m = 0; m < 4; m++) begin
      for (int n = 119; n >= 39; n--) begin
        longint unsigned vco;
        vco = fin * 64'(n + 1) / 64'(m + 1);
        if (vco < 64'd1000 || vco > 64'd2048000000) begin
          r.cyc++;
          continue;
        end
        for (int p = 1; p <= 31; p++) begin
          longint unsigned o, d;
          r.cyc++;
          o = vco / 64'(p + 1);
          if (o >= 64'd400000000) continue;
          d = (o >= tgt) ? (o - tgt) : (tgt - o);
          if (d < r.err) begin
            r.m = 64'(m); r.n = 64'(n); r.p = 64'(p); r.outF = o; r.err = d;
          end
          if (d == 0) return r;
        end
      end
    end
    return r;
  endfunction

  task automatic cmpAll(input string tag, input exp_t e);
    chk({tag, " R2/R6 codeM"}, 64'(codeM), e.m);
    chk({tag, " R3/R6 codeN"}, 64'(codeN), e.n);
    chk({tag, " R3/R6 codeP"}, 64'(codeP), e.p);
    chk({tag, " R2/R5 outFreq"}, 64'(outFreq), e.outF);
    chk({tag, " R4/R8 absErr"}, 64'(absErr), e.err);
  endtask

  // Monitor: pops the expected item when done is seen.
  initial begin
    forever begin
      @(negedge clk);
      if (done) begin
        if (sbQ.size() == 0) begin
          chk("R9 unexpected done", 64'd1, 64'd0);
        end else begin
          exp_t e;
          e = sbQ.pop_front();
          cmpAll("result", e);
          chk("R9 R7 R3 latency", cycCnt - startAt, e.cyc);
          @(negedge clk);
          chk("R9 done pulse width", 64'(done), 64'd0);
        end
      end
    end
  end

  // Driver: pushes expectation, strobes start, then checks hold (R10).
  task automatic runSearch(input longint unsigned fin, input longint unsigned tgt);
    exp_t e;
    e = model(fin, tgt);
    sbQ.push_back(e);
    @(negedge clk);
    refFreq    = fin[31:0];
    targetFreq = tgt[31:0];
    start      = 1'b1;
    startAt    = cycCnt + 64'd1;
    @(negedge clk);
    start = 1'b0;
    wait (sbQ.size() == 0);
    repeat (6) @(negedge clk);
    cmpAll("R10 hold", e);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1 done", 64'(done), 64'd0);
    chk("R1 codeM", 64'(codeM), 64'd0);
    chk("R1 codeN", 64'(codeN), 64'd0);
    chk("R1 codeP", 64'(codeP), 64'd0);
    chk("R1 outFreq", 64'(outFreq), 64'd0);
    chk("R1 absErr", 64'(absErr), 64'hFFFFFFFF);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R7: exact hit on the third candidate (m0 n119 p3), after two R5 rejects
    runSearch(64'd10000000, 64'd300000000);
    chk("R7 hand codeP", 64'(codeP), 64'd3);
    chk("R7 hand err", 64'(absErr), 64'd0);
    // R8/R4 low side: intermediate never reaches 1000; also R10 clears previous result
    runSearch(64'd5, 64'd1000);
    // R8/R4 high side: intermediate always above the window
    runSearch(64'd4000000000, 64'd100000000);
    // R4 edge: fin*(n+1) hits exactly 1000 at m0 n99
    runSearch(64'd10, 64'd500);
    // R6: ties with later candidates must keep the first
    runSearch(64'd10000000, 64'd300000001);
    // R5: target on the ceiling itself
    runSearch(64'd10000000, 64'd400000000);
    // R2: division by 3 with truncation, full walk
    runSearch(64'd10000001, 64'd74250000);
    // Typical pixel clocks
    runSearch(64'd33333333, 64'd148500000);
    runSearch(64'd24000000, 64'd25175000);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errCnt++;
      $display("FAIL watchdog R9 actual=timeout expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
      $finish;
    end
  end

endmodule